// File: doc/BRIEF.md
# Stop-Grant Clock-Gating Sequencer

This block sits on the processor side of a power-management handshake. The system raises an active-low stop request. The sequencer does not act on it right away. It first filters the request for width, then waits for an instruction-retire boundary, and only then walks the core through a fixed order of steps:

1. Empty the pipelines.
2. Let the bus go quiet.
3. Announce the event with a stop-grant special bus cycle.
4. Gate the internal clock off.

Once the clock is gated, the sequencer can move further into a stop-clock state. It does so only if the system removes the bus clock.

The pipeline, the bus unit and the clock generator are outside this block. Each one is represented by a plain handshake input or output. A bus-clock-present input stands in for the physical bus clock, so the stop-clock state can be modelled while the block's own clock keeps running. Gating the internal clock waits for two conditions: bus ready for the special cycle, and a write-buffer-empty indication. The write-buffer-empty condition can be excluded with a mask input.

Top module: `stopgrant_seq`

## Requirements
- R1: During and after reset, `state_o` reads 0 (normal), `core_clk_en` is 1, and `flush_req` and `spc_req` are 0. `spc_type` is 0.
- R2: The request passes through a two-stage synchroniser and a width filter. A low pulse on `stop_req_n` that lasts one clock is ignored, and `state_o` stays 0. A request held low is recognised: `state_o` becomes 1 (waiting for a boundary) four clocks after it is first sampled low.
- R3: While `state_o` is 1, no flush is requested until `retire_bnd` is sampled high. One clock after that, `state_o` is 2 and `flush_req` is 1. Both hold until `flush_done` is sampled high.
- R4: If the request is released while `state_o` is 1, the sequence is cancelled. `state_o` returns to 0 and `flush_req` never rises.
- R5: After `flush_done`, `state_o` is 3 (draining the bus). The special cycle is not requested until `bus_idle` is sampled high.
- R6: In state 4, `spc_req` is 1 and `spc_type` carries the stop-grant code (default 3'b101), and `spc_req` stays high until `bus_ready` is sampled high. Whenever `spc_req` is 0, `spc_type` is 0.
- R7: `core_clk_en` falls only after `bus_ready` is sampled with `spc_req` high. With `wb_ignore` 0, the write buffer must also be empty: if `wb_empty` is 0 when bus ready arrives, `state_o` is 5. The clock stays enabled until `wb_empty` is sampled 1, and then `state_o` is 6 (stop-grant) with `core_clk_en` 0.
- R8: With `wb_ignore` 1, `wb_empty` has no effect. On `bus_ready`, `state_o` goes directly from 4 to 6.
- R9: In state 6, `busclk_on` sampled 0 moves `state_o` to 7 (stop-clock). `busclk_on` sampled 1 returns it to 6. `core_clk_en` stays 0 in both states.
- R10: Releasing the request in state 6 returns `state_o` to 0, with `core_clk_en` 1, three clocks after the release is first sampled. A release after the flush has begun does not abort the sequence: it still reaches state 6 and then returns to 0.
- R11: At most one of the following holds at any time: `flush_req` high, `spc_req` high, `core_clk_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Active-low stop request, may be asynchronous |
| retire_bnd | input | 1 | Instruction-retire boundary strobe |
| flush_done | input | 1 | Pipeline flush finished |
| bus_idle | input | 1 | No pending or in-progress bus cycles |
| bus_ready | input | 1 | Ready for the current bus cycle |
| wb_empty | input | 1 | Write buffer empty |
| wb_ignore | input | 1 | 1 excludes `wb_empty` from stop-grant entry |
| busclk_on | input | 1 | Bus clock present |
| flush_req | output | 1 | Request to flush the pipelines |
| spc_req | output | 1 | Special bus cycle request |
| spc_type | output | TYPE_W | Special cycle type code, 0 when idle |
| core_clk_en | output | 1 | Internal clock enable |
| state_o | output | 3 | Current sequencer state code |

## Verification
A wrong state shows up at the ports within one clock. `state_o` follows the state register directly, and every handshake output is a pure function of that state. A skipped step, for example, appears as `spc_req` rising before `bus_idle` was seen, or as `core_clk_en` falling before bus ready and the write-buffer check. A fault in the request filter appears as a shift in the exact four-clock recognition latency, or in the three-clock release latency. It also appears as a one-clock pulse reaching state 1. The sweeps over the mask and buffer-empty combinations show which branch leaves state 4.

// File: rtl/stopgrant_pkg.sv
package stopgrant_pkg;
   localparam int STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      SG_NORMAL  = 3'd0,
      SG_ARMED   = 3'd1,
      SG_FLUSH   = 3'd2,
      SG_DRAIN   = 3'd3,
      SG_SPECIAL = 3'd4,
      SG_WBWAIT  = 3'd5,
      SG_GRANT   = 3'd6,
      SG_STOPCLK = 3'd7
   } sg_state_e;
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("sg_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sg_width_filter.sv
module sg_width_filter #(
   parameter int MIN_WIDTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_in,
   output logic req_ok
);
   generate
      if (MIN_WIDTH < 1) begin : g_bad
         $error("sg_width_filter needs MIN_WIDTH of at least one");
      end else if (MIN_WIDTH == 1) begin : g_pass
         assign req_ok = req_in;
      end else begin : g_count
         localparam int CNT_W = $clog2(MIN_WIDTH);
         localparam logic [CNT_W-1:0] SAT = CNT_W'(MIN_WIDTH - 1);
         logic [CNT_W-1:0] run_len;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            run_len <= '0;
            else if (!req_in)      run_len <= '0;
            else if (run_len != SAT) run_len <= run_len + 1'b1;
         end

         assign req_ok = req_in && (run_len == SAT);
      end
   endgenerate
endmodule

// File: rtl/sg_fsm.sv
module sg_fsm
   import stopgrant_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_ok,
   input  logic      retire_bnd,
   input  logic      flush_done,
   input  logic      bus_idle,
   input  logic      bus_ready,
   input  logic      wb_clear,
   input  logic      busclk_on,
   output sg_state_e state
);
   sg_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         SG_NORMAL:  if (req_ok) nxt = SG_ARMED;
         SG_ARMED: begin
            if (!req_ok)         nxt = SG_NORMAL;
            else if (retire_bnd) nxt = SG_FLUSH;
         end
         SG_FLUSH:   if (flush_done) nxt = SG_DRAIN;
         SG_DRAIN:   if (bus_idle)   nxt = SG_SPECIAL;
         SG_SPECIAL: if (bus_ready)  nxt = wb_clear ? SG_GRANT : SG_WBWAIT;
         SG_WBWAIT:  if (wb_clear)   nxt = SG_GRANT;
         SG_GRANT: begin
            if (!busclk_on)   nxt = SG_STOPCLK;
            else if (!req_ok) nxt = SG_NORMAL;
         end
         SG_STOPCLK: if (busclk_on)  nxt = SG_GRANT;
         default:    nxt = SG_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SG_NORMAL;
      else        state <= nxt;
   end
endmodule

// File: rtl/stopgrant_seq.sv
module stopgrant_seq
   import stopgrant_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                MIN_WIDTH   = 2,
   parameter int                TYPE_W      = 3,
   parameter logic [TYPE_W-1:0] SG_CODE     = 3'b101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_req_n,
   input  logic              retire_bnd,
   input  logic              flush_done,
   input  logic              bus_idle,
   input  logic              bus_ready,
   input  logic              wb_empty,
   input  logic              wb_ignore,
   input  logic              busclk_on,
   output logic              flush_req,
   output logic              spc_req,
   output logic [TYPE_W-1:0] spc_type,
   output logic              core_clk_en,
   output logic [2:0]        state_o
);
   generate
      if (TYPE_W < 1) begin : g_bad_type
         $error("stopgrant_seq needs TYPE_W of at least one");
      end
      if (SG_CODE == '0) begin : g_bad_code
         $error("stop-grant code must differ from the idle value");
      end
   endgenerate

   logic      req_sync;
   logic      req_ok;
   logic      wb_clear;
   sg_state_e state;

   sg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (~stop_req_n),
      .q     (req_sync)
   );

   sg_width_filter #(.MIN_WIDTH(MIN_WIDTH)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_in (req_sync),
      .req_ok (req_ok)
   );

   assign wb_clear = wb_ignore | wb_empty;

   sg_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_ok     (req_ok),
      .retire_bnd (retire_bnd),
      .flush_done (flush_done),
      .bus_idle   (bus_idle),
      .bus_ready  (bus_ready),
      .wb_clear   (wb_clear),
      .busclk_on  (busclk_on),
      .state      (state)
   );

   assign flush_req   = (state == SG_FLUSH);
   assign spc_req     = (state == SG_SPECIAL);
   assign spc_type    = spc_req ? SG_CODE : '0;
   assign core_clk_en = !((state == SG_GRANT) || (state == SG_STOPCLK));
   assign state_o     = state;
endmodule

// File: rtl/stopgrant_seq_chk.sv
module stopgrant_seq_chk #(
   parameter int                TYPE_W  = 3,
   parameter logic [TYPE_W-1:0] SG_CODE = 3'b101
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_req_n,
   input logic              retire_bnd,
   input logic              flush_done,
   input logic              bus_idle,
   input logic              bus_ready,
   input logic              wb_empty,
   input logic              wb_ignore,
   input logic              busclk_on,
   input logic              flush_req,
   input logic              spc_req,
   input logic [TYPE_W-1:0] spc_type,
   input logic              core_clk_en,
   input logic [2:0]        state_o
);
   // R3
   flush_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flush_req) |-> $past(retire_bnd));

   // R5
   special_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spc_req) |-> $past(bus_idle));

   // R6
   special_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spc_req && !bus_ready) |=> spc_req);

   // R6
   special_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spc_req |-> (spc_type == SG_CODE));

   // R7
   gate_needs_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_clk_en) |-> $past(wb_ignore || wb_empty));

   // R7
   gate_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_clk_en) |-> ($past(spc_req && bus_ready) || $past(state_o == 3'd5)));

   // R9
   stopclk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_o == 3'd7) |-> $past(!busclk_on));

   // R11
   exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flush_req, spc_req, !core_clk_en}));
endmodule

bind stopgrant_seq stopgrant_seq_chk #(.TYPE_W(TYPE_W), .SG_CODE(SG_CODE)) u_chk (.*);

// File: tb/stopgrant_seq_tb.sv
`timescale 1ns/1ps
module stopgrant_seq_tb;
   localparam int TYPE_W = 3;
   localparam logic [TYPE_W-1:0] CODE = 3'b101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_req_n = 1'b1;
   logic retire_bnd = 1'b0, flush_done = 1'b0, bus_idle = 1'b0, bus_ready = 1'b0;
   logic wb_empty = 1'b0, wb_ignore = 1'b0, busclk_on = 1'b1;
   logic flush_req, spc_req, core_clk_en;
   logic [TYPE_W-1:0] spc_type;
   logic [2:0] state_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   stopgrant_seq #(.TYPE_W(TYPE_W), .SG_CODE(CODE)) u_dut (
      .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .retire_bnd(retire_bnd),
      .flush_done(flush_done), .bus_idle(bus_idle), .bus_ready(bus_ready),
      .wb_empty(wb_empty), .wb_ignore(wb_ignore), .busclk_on(busclk_on),
      .flush_req(flush_req), .spc_req(spc_req), .spc_type(spc_type),
      .core_clk_en(core_clk_en), .state_o(state_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // drive a held request and follow it into the special cycle
   task automatic to_special();
      stop_req_n = 1'b0;
      tick(3); chk("R2 not yet recognised", state_o, 0);
      tick(1); chk("R2 recognised", state_o, 1);
      retire_bnd = 1'b1; tick(1); retire_bnd = 1'b0;
      chk("R3 flush state", state_o, 2);
      flush_done = 1'b1; tick(1); flush_done = 1'b0;
      chk("R5 drain state", state_o, 3);
      bus_idle = 1'b1; tick(1); bus_idle = 1'b0;
      chk("R6 special state", state_o, 4);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      tick(3);
      chk("R1 state in reset", state_o, 0);
      chk("R1 clk_en in reset", core_clk_en, 1);
      rst_n = 1'b1;
      tick(2);
      chk("R1 state", state_o, 0);
      chk("R1 clk_en", core_clk_en, 1);
      chk("R1 flush_req", flush_req, 0);
      chk("R1 spc_req", spc_req, 0);
      chk("R1 spc_type", spc_type, 0);

      // R2: one-clock pulse is ignored
      stop_req_n = 1'b0; tick(1); stop_req_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         tick(1); chk("R2 short pulse ignored", state_o, 0);
      end

      // R4: two-clock pulse arms then cancels
      stop_req_n = 1'b0; tick(2); stop_req_n = 1'b1;
      tick(2); chk("R4 armed by wide pulse", state_o, 1);
      tick(1); chk("R4 cancelled", state_o, 0);
      chk("R4 no flush", flush_req, 0);
      tick(3);

      // R3: hold without boundary
      stop_req_n = 1'b0; tick(4);
      chk("R3 armed", state_o, 1);
      for (int i = 0; i < 8; i++) begin
         tick(1); chk("R3 waits for boundary", flush_req, 0);
      end
      retire_bnd = 1'b1; tick(1); retire_bnd = 1'b0;
      chk("R3 flush_req", flush_req, 1);
      tick(4); chk("R3 flush held", flush_req, 1);
      flush_done = 1'b1; tick(1); flush_done = 1'b0;
      chk("R5 drain", state_o, 3);
      tick(4); chk("R5 no special before idle", spc_req, 0);
      bus_idle = 1'b1; tick(1); bus_idle = 1'b0;
      chk("R6 spc_req", spc_req, 1);
      chk("R6 spc_type", spc_type, CODE);
      tick(5); chk("R6 held until ready", spc_req, 1);
      bus_ready = 1'b1; tick(1); bus_ready = 1'b0;
      chk("R7 wb wait state", state_o, 5);
      chk("R7 clock still on", core_clk_en, 1);
      chk("R6 spc_type idle", spc_type, 0);
      tick(3); chk("R7 still waiting for buffer", core_clk_en, 1);
      wb_empty = 1'b1; tick(1);
      chk("R7 stop grant", state_o, 6);
      chk("R7 clock off", core_clk_en, 0);
      busclk_on = 1'b0; tick(1);
      chk("R9 stop clock", state_o, 7);
      tick(3); chk("R9 clock off in stop clock", core_clk_en, 0);
      busclk_on = 1'b1; tick(1);
      chk("R9 back to grant", state_o, 6);
      stop_req_n = 1'b1;
      tick(2); chk("R10 still granted", state_o, 6);
      tick(1); chk("R10 normal", state_o, 0);
      chk("R10 clock on", core_clk_en, 1);
      wb_empty = 1'b0;
      tick(3);

      // R7/R8 sweep over mask and buffer-empty
      for (int m = 0; m < 2; m++) begin
         for (int e = 0; e < 2; e++) begin
            to_special();
            wb_ignore = m[0]; wb_empty = e[0]; bus_ready = 1'b1;
            tick(1); bus_ready = 1'b0;
            if (m == 1) chk("R8 mask ignores buffer", state_o, 6);
            else        chk("R7 buffer gate", state_o, (e == 1) ? 6 : 5);
            if (state_o == 3'd5) begin
               wb_empty = 1'b1; tick(1);
               chk("R7 buffer drained", state_o, 6);
            end
            stop_req_n = 1'b1; tick(3);
            chk("R10 release", state_o, 0);
            wb_ignore = 1'b0; wb_empty = 1'b0;
            tick(3);
         end
      end

      // R10: release after flush began does not abort
      stop_req_n = 1'b0; tick(4);
      retire_bnd = 1'b1; tick(1); retire_bnd = 1'b0;
      chk("R10 in flush", state_o, 2);
      stop_req_n = 1'b1; flush_done = 1'b1; bus_idle = 1'b1; bus_ready = 1'b1; wb_ignore = 1'b1;
      tick(1); chk("R10 drain after release", state_o, 3);
      tick(1); chk("R10 special after release", state_o, 4);
      tick(1); chk("R10 reaches grant", state_o, 6);
      tick(1); chk("R10 back to normal", state_o, 0);
      flush_done = 1'b0; bus_idle = 1'b0; bus_ready = 1'b0; wb_ignore = 1'b0;
      tick(2);
      summary();
   end
endmodule